// File: doc/BRIEF.md
# Dense-Polynomial Galois LFSR Engine

This block is a pseudo-random state generator built on a very dense feedback polynomial. The polynomial has every bit set except bits 0 and 2. That is 0xFFFFFFFA at the default width of 32 and 0xFA at width 8, and both are primitive. On each enabled cycle the register shifts right by one. The old least significant bit wraps into the top bit, and it is XORed into every lower bit position whose polynomial bit is set. The full state is presented on the output in every cycle.

Two independent implementations run side by side:

- **Reference register.** This form holds the whole state.
- **Reduced engine.** This form keeps one flop per XOR gate plus three history flops. It feeds each XOR from values that are one, two or three steps old.

A registered flag reports any difference between the state rebuilt from the reduced engine and the reference register.

A seed can be loaded at any time, and loading takes priority over advancing. A zero seed would lock the generator, so it is replaced by the value 1. The same parameterised top serves the 32-bit generator and the 8-bit variant, which is used for full-period checks.

Top module: `dense_galois_lfsr`

## Requirements
- R1: While reset is asserted and right after it is released, `state` equals 1 (only bit 0 set) and `mismatch` is 0.
- R2: With `adv_en` high and `seed_load` low, the next state is computed from the old state `s` as follows:
  - bit W-1 becomes `s[0]`;
  - every lower bit j becomes `s[j+1] ^ (s[0] & P[j])`;
  - P is all ones except bits 0 and 2 (0xFFFFFFFA for W=32, 0xFA for W=8).
- R3: With `seed_load` high and `seed_val` nonzero, `state` equals `seed_val` after the next clock edge.
- R4: A load of a zero seed produces `state` equal to 1 after the next clock edge.
- R5: When `seed_load` and `adv_en` are both high, the load wins and no step is applied.
- R6: With `seed_load` and `adv_en` both low, `state` and `mismatch` hold their values.
- R7: The reduced engine stores W-3 XOR-result flops plus three history flops. The state rebuilt from it equals the reference state in every cycle, so `mismatch` stays 0 after every advance.
- R8: At W=8, from any nonzero seed, the state returns to that seed after exactly 255 advances and not earlier.
- R9: `state` is never zero.
- R10: A seed load clears `mismatch` at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| seed_load | input | 1 | Load `seed_val` into both implementations |
| seed_val | input | W | Seed value (zero is replaced by 1) |
| adv_en | input | 1 | Advance the generator by one step |
| state | output | W | Current state of the reference register |
| mismatch | output | 1 | Set when the reduced engine disagrees with the reference after an advance |

## Verification
The two functions that can meet in one cycle are seed loading and advancing. The bench raises both in the same cycle, once with a nonzero seed and once with a zero seed. It judges the result by requiring the state one edge later to equal the loaded (or substituted) seed rather than a stepped value, with the mismatch flag at 0. Over long runs from several seeds, the advance enable is also dropped at irregular intervals, so that held cycles fall between steps and after loads.

// File: rtl/dense_lfsr_pkg.sv
package dense_lfsr_pkg;

  // Dense feedback mask of width w (w <= 64): all ones except bits 0 and 2.
  function automatic logic [63:0] dense_poly(input int w);
    logic [63:0] m;
    m = (w >= 64) ? {64{1'b1}} : ((64'd1 << w) - 64'd1);
    return m & ~64'h5;
  endfunction

endpackage

// File: rtl/dlfsr_ref_reg.sv
module dlfsr_ref_reg #(
  parameter int              W       = 32,
  parameter logic [W-1:0]    POLY    = '1,
  parameter logic [W-1:0]    RST_VAL = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         adv,
  input  logic [W-1:0] seed,
  output logic [W-1:0] state_q,
  output logic [W-1:0] state_d
);

  logic [W-1:0] stepped;
  logic         en;

  // Shift right with wrap; lower set mask bits toggle with the old LSB.
  always_comb begin
    stepped[W-1] = state_q[0];
    for (int j = 0; j < W-1; j++) begin
      stepped[j] = state_q[j+1] ^ (state_q[0] & POLY[j]);
    end
  end

  always_comb begin
    en = load | adv;
    if (load)      state_d = seed;
    else if (adv)  state_d = stepped;
    else           state_d = state_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   state_q <= RST_VAL;
    else if (en)  state_q <= state_d;
  end

  assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load) |=> state_q[W-1] == $past(state_q[0]));

  assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> state_q == $past(seed));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !adv) |=> $stable(state_q));

  assert_nonzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);

endmodule

// File: rtl/dlfsr_reduced.sv
module dlfsr_reduced #(
  parameter int           W       = 32,
  parameter logic [W-1:0] RST_VAL = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         adv,
  input  logic [W-1:0] seed,
  output logic [W-1:0] full_q,
  output logic [W-1:0] full_d
);

  // Layout of the packed register:
  //   [NG-1:0] one flop per XOR gate (state bit 1, then bits 3..W-2)
  //   [HA]     gate 0 one step back  (equals state bit 0)
  //   [HB]     gate 1 one step back  (equals state bit 2)
  //   [HC]     gate 0 two steps back (equals state bit W-1)
  localparam int NG = W - 3;
  localparam int HA = NG;
  localparam int HB = NG + 1;
  localparam int HC = NG + 2;
  localparam int RW = NG + 3;

  function automatic logic [RW-1:0] fold(input logic [W-1:0] s);
    logic [RW-1:0] r;
    r[0] = s[1];
    for (int i = 1; i < NG; i++) r[i] = s[i+2];
    r[HA] = s[0];
    r[HB] = s[2];
    r[HC] = s[W-1];
    return r;
  endfunction

  function automatic logic [W-1:0] unfold(input logic [RW-1:0] r);
    logic [W-1:0] s;
    s[0] = r[HA];
    s[1] = r[0];
    s[2] = r[HB];
    for (int i = 1; i < NG; i++) s[i+2] = r[i];
    s[W-1] = r[HC];
    return s;
  endfunction

  localparam logic [RW-1:0] RST_R = fold(RST_VAL);

  logic [RW-1:0] vec_q, vec_d, step_v, seed_v;
  logic          en;

  // Gate 0: second operand is gate 1 from two steps ago.
  assign step_v[0] = vec_q[HB] ^ vec_q[HA];

  // Middle gates: second operand is the next gate from one step ago.
  for (genvar i = 1; i < NG-1; i++) begin : g_mid
    assign step_v[i] = vec_q[i+1] ^ vec_q[HA];
  end

  // Last gate: second operand is gate 0 from three steps ago.
  assign step_v[NG-1] = vec_q[HC] ^ vec_q[HA];

  // History taps shift along.
  assign step_v[HA] = vec_q[0];
  assign step_v[HB] = vec_q[1];
  assign step_v[HC] = vec_q[HA];

  assign seed_v = fold(seed);

  always_comb begin
    en = load | adv;
    if (load)      vec_d = seed_v;
    else if (adv)  vec_d = step_v;
    else           vec_d = vec_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   vec_q <= RST_R;
    else if (en)  vec_q <= vec_d;
  end

  assign full_q = unfold(vec_q);
  assign full_d = unfold(vec_d);

  assert_hist_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load) |=> vec_q[HC] == $past(vec_q[HA]));

endmodule

// File: rtl/dlfsr_cmp.sv
module dlfsr_cmp #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         adv,
  input  logic [W-1:0] ref_d,
  input  logic [W-1:0] alt_d,
  output logic         mismatch_q
);

  logic mm_d;
  logic en;

  always_comb begin
    en   = load | adv;
    mm_d = load ? 1'b0 : (ref_d != alt_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   mismatch_q <= 1'b0;
    else if (en)  mismatch_q <= mm_d;
  end

  assert_flag_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !adv) |=> $stable(mismatch_q));

  assert_flag_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !mismatch_q);

endmodule

// File: rtl/dense_galois_lfsr.sv
module dense_galois_lfsr
  import dense_lfsr_pkg::*;
#(
  parameter int           W            = 32,
  parameter logic [W-1:0] DEFAULT_SEED = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         seed_load,
  input  logic [W-1:0] seed_val,
  input  logic         adv_en,
  output logic [W-1:0] state,
  output logic         mismatch
);

  localparam logic [63:0]  POLY_WIDE = dense_poly(W);
  localparam logic [W-1:0] POLY      = POLY_WIDE[W-1:0];

  logic [W-1:0] seed_eff;
  logic [W-1:0] ref_q, ref_d, alt_q, alt_d;

  assign seed_eff = (seed_val == '0) ? DEFAULT_SEED : seed_val;

  dlfsr_ref_reg #(.W(W), .POLY(POLY), .RST_VAL(DEFAULT_SEED)) u_ref (
    .clk(clk), .rst_n(rst_n), .load(seed_load), .adv(adv_en),
    .seed(seed_eff), .state_q(ref_q), .state_d(ref_d)
  );

  dlfsr_reduced #(.W(W), .RST_VAL(DEFAULT_SEED)) u_alt (
    .clk(clk), .rst_n(rst_n), .load(seed_load), .adv(adv_en),
    .seed(seed_eff), .full_q(alt_q), .full_d(alt_d)
  );

  dlfsr_cmp #(.W(W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .load(seed_load), .adv(adv_en),
    .ref_d(ref_d), .alt_d(alt_d), .mismatch_q(mismatch)
  );

  assign state = ref_q;

  assert_zero_seed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (seed_load && seed_val == '0) |=> state == DEFAULT_SEED);

  assert_load_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (seed_load && adv_en && seed_val != '0) |=> state == $past(seed_val));

  assert_equiv_R7: assert property (@(posedge clk) disable iff (!rst_n)
    alt_q == ref_q);

endmodule

// File: tb/dense_galois_lfsr_test.sv
`timescale 1ns/1ps
module dense_galois_lfsr_test;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n;
  logic        ld32, adv32, ld8, adv8;
  logic [31:0] seed32;
  logic [7:0]  seed8;
  logic [31:0] st32;
  logic [7:0]  st8;
  logic        mm32, mm8;

  dense_galois_lfsr #(.W(32)) uut (
    .clk(clk), .rst_n(rst_n), .seed_load(ld32), .seed_val(seed32),
    .adv_en(adv32), .state(st32), .mismatch(mm32)
  );

  dense_galois_lfsr #(.W(8)) uut_small (
    .clk(clk), .rst_n(rst_n), .seed_load(ld8), .seed_val(seed8),
    .adv_en(adv8), .state(st8), .mismatch(mm8)
  );

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;
  bit zero_seen = 1'b0;
  logic [31:0] m32;
  logic [7:0]  m8;

  function automatic logic [31:0] gstep(input logic [31:0] s, input int w);
    logic [31:0] mask;
    logic [31:0] p;
    mask = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    p    = mask & ~32'h5;
    return (s >> 1) ^ (s[0] ? p : 32'h0);
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // One 32-bit cycle: drive at negedge, model at posedge, sample 1 ns later.
  task automatic cyc32(input bit ld, input bit adv, input logic [31:0] sd, input string req);
    @(negedge clk);
    ld32 = ld; adv32 = adv; seed32 = sd;
    @(posedge clk);
    if (ld)       m32 = (sd == 32'h0) ? 32'h1 : sd;
    else if (adv) m32 = gstep(m32, 32);
    #1;
    check(req, st32, m32);
    check("R7", {31'h0, mm32}, 32'h0);
    if (st32 == 32'h0) zero_seen = 1'b1;
  endtask

  task automatic cyc8(input bit ld, input bit adv, input logic [7:0] sd);
    @(negedge clk);
    ld8 = ld; adv8 = adv; seed8 = sd;
    @(posedge clk);
    if (ld)       m8 = (sd == 8'h0) ? 8'h1 : sd;
    else if (adv) m8 = 8'(gstep({24'h0, m8}, 8));
    #1;
    check("R2 (8-bit)", {24'h0, st8}, {24'h0, m8});
    check("R7 (8-bit)", {31'h0, mm8}, 32'h0);
    if (st8 == 8'h0) zero_seen = 1'b1;
  endtask

  task automatic run32(input logic [31:0] sd, input int n);
    cyc32(1'b1, 1'b0, sd, "R3");
    for (int k = 0; k < n; k++) begin
      if (k % 13 == 7) cyc32(1'b0, 1'b0, 32'h0, "R6");
      else             cyc32(1'b0, 1'b1, 32'h0, "R2");
    end
  endtask

  task automatic period8(input logic [7:0] sd);
    int early;
    early = 0;
    cyc8(1'b1, 1'b0, sd);
    for (int k = 1; k <= 255; k++) begin
      cyc8(1'b0, 1'b1, 8'h0);
      if (k < 255 && st8 == sd) early++;
    end
    check("R8 return after 255", {24'h0, st8}, {24'h0, sd});
    check("R8 no early return", early, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    ld32 = 0; adv32 = 0; seed32 = 0;
    ld8 = 0; adv8 = 0; seed8 = 0;
    m32 = 32'h1; m8 = 8'h1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 state in reset", st32, 32'h1);
    check("R1 mismatch in reset", {31'h0, mm32}, 32'h0);
    check("R1 small state in reset", {24'h0, st8}, 32'h1);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 state after release", st32, 32'h1);

    // Hold with the enable low
    for (int k = 0; k < 4; k++) cyc32(1'b0, 1'b0, 32'h0, "R6");

    // Steps from the default seed
    for (int k = 0; k < 40; k++) cyc32(1'b0, 1'b1, 32'h0, "R2");

    // Long runs from several seeds, with held cycles mixed in
    run32(32'hDEAD_BEEF, 3500);

    // Zero seed replaced by 1
    cyc32(1'b1, 1'b0, 32'h0, "R4");
    for (int k = 0; k < 3; k++) cyc32(1'b0, 1'b1, 32'h0, "R2");

    // Load and advance in the same cycle: load wins
    cyc32(1'b1, 1'b1, 32'h1234_5678, "R5");
    cyc32(1'b0, 1'b1, 32'h0, "R2");
    cyc32(1'b1, 1'b1, 32'h0, "R5 with R4 zero seed");
    check("R10 mismatch clear after load", {31'h0, mm32}, 32'h0);

    run32(32'h8000_0000, 3500);
    run32(32'hFFFF_FFFF, 3500);

    // Small variant idled during the long run: still at reset value
    check("R6 small idle", {24'h0, st8}, 32'h1);

    period8(8'h01);
    period8(8'hA5);
    cyc8(1'b1, 1'b1, 8'h00);
    check("R4 small zero seed", {24'h0, st8}, 32'h1);

    check("R9 state never zero", {31'h0, zero_seen}, 32'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule